// File: doc/BRIEF.md
# Inter-processor word FIFO channel

This block joins two processors, called side A and side B, with a pair of one-way queues of 32-bit words. A word that one side writes to its send register goes into a queue. The other side takes it out, oldest first, by reading its receive register. Both sides run on the same clock, and each side sees the same register set through its own simple access port.

Each side also has a control register. It shows the empty and full state of the queue that side sends into and of the queue it receives from. It holds two interrupt enables, a flush command for its own send queue, a sticky error flag and an enable bit. The enable bit gates that side's sends and receives. Each side drives two level interrupts. One is raised while its send queue is empty. The other is raised while its receive queue holds at least one word.

A register access takes one cycle with `sel` high. With `wr` high the access is a write, which takes effect at the clock edge. With `wr` low it is a read: `rdata` is valid in the same cycle, and a read of the receive register removes the word at that edge. Both queues are parameterised and are 16 words deep by default.

Top module: `ipc_word_channel`

## Requirements
- R1: After reset, the control register of each side reads 0x0101: bit 0 (send queue empty) and bit 8 (receive queue empty) are 1, and every other bit is 0. Both interrupts of each side are low, and a receive read returns 0.
- R2: Words written by one side are read back by the other side in the order they were written, and each queue holds up to DEPTH words.
- R3: Control bit 0 reads 1 when the local send queue is empty, and bit 1 reads 1 when it holds DEPTH words. Bit 8 reads 1 when the local receive queue is empty, and bit 9 reads 1 when it is full.
- R4: An enabled send to a full queue drops the word, leaves the queue unchanged and sets error bit 14 of the sending side.
- R5: An enabled read of an empty receive queue returns the last word that side received, or 0 if it has received none. The read leaves the queue unchanged and sets error bit 14 of the reading side.
- R6: Writing the control register with bit 14 set clears the error flag. Writing it with bit 14 clear leaves the flag as it was.
- R7: Writing the control register with bit 3 set empties that side's send queue, which is the peer's receive queue. Writing bit 3 as 0 has no effect, and bit 3 always reads 0.
- R8: While control bit 15 of a side is 0, that side's sends and receive reads are ignored: no word enters or leaves a queue, the error flag does not change, and a receive read returns the last received word. Status bits and flush still work while the bit is 0.
- R9: The send-empty interrupt of a side is high exactly while control bit 2 is 1 and that side's send queue is empty.
- R10: The receive interrupt of a side is high exactly while control bit 10 is 1 and that side's receive queue is not empty.
- R11: The control register is at byte offset 0x4 (`addr` = 1), the send register at 0x8 (`addr` = 2) and the receive register at 0xC (`addr` = 3). A read at offset 0x0 or of the send register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 2 | Side A word address (byte offset / 4) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the access cycle |
| a_irq_send_empty | output | 1 | Side A send-queue-empty interrupt |
| a_irq_recv_avail | output | 1 | Side A receive-queue-not-empty interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 2 | Side B word address (byte offset / 4) |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the access cycle |
| b_irq_send_empty | output | 1 | Side B send-queue-empty interrupt |
| b_irq_recv_avail | output | 1 | Side B receive-queue-not-empty interrupt |

## Verification
The bench builds the channel with DEPTH = 4 and the default 32-bit width. The shallow queue lets every fill level be swept from empty to one past full in both directions. It brings overflow and underflow, the full flags and the error flag within a few cycles of each other. Each sweep step compares status, read data and interrupts against a queue model in the bench. Separate passes cover flush from each side, the enable gate and the write-one-to-clear error flag.

// File: rtl/ipc_chan_pkg.sv
package ipc_chan_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_SEND = 2'd2,
    REG_RECV = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_TX_EMPTY  = 0;
  localparam int unsigned CB_TX_FULL   = 1;
  localparam int unsigned CB_TX_IRQEN  = 2;
  localparam int unsigned CB_TX_FLUSH  = 3;
  localparam int unsigned CB_RX_EMPTY  = 8;
  localparam int unsigned CB_RX_FULL   = 9;
  localparam int unsigned CB_RX_IRQEN  = 10;
  localparam int unsigned CB_ERR       = 14;
  localparam int unsigned CB_ENABLE    = 15;
  localparam int unsigned CTRL_BITS    = 16;

endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] pdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_nxt;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_nxt;
  logic [CW-1:0]    count_q, count_nxt;
  logic             do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == FULL_CNT);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_nxt = wr_ptr_q;
    rd_ptr_nxt = rd_ptr_q;
    count_nxt  = count_q;
    if (flush) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      count_nxt  = '0;
    end else begin
      if (do_push) wr_ptr_nxt = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_nxt = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_nxt = count_q + 1'b1;
        2'b01:   count_nxt = count_q - 1'b1;
        default: count_nxt = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      count_q  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= pdata;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && wr_ptr_q == $past(wr_ptr_q)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/ipc_side_regs.sv
module ipc_side_regs
  import ipc_chan_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             tx_empty,
  input  logic             tx_full,
  input  logic             rx_empty,
  input  logic             rx_full,
  input  logic [WIDTH-1:0] rx_head,
  output logic             tx_push,
  output logic             tx_flush,
  output logic             rx_pop,
  output logic             irq_tx_empty,
  output logic             irq_rx_avail
);

  reg_sel_e             rsel;
  logic                 wr_ctrl, wr_send, rd_recv, err_set;
  logic                 en_q, en_nxt;
  logic                 txie_q, txie_nxt;
  logic                 rxie_q, rxie_nxt;
  logic                 err_q, err_nxt;
  logic [WIDTH-1:0]     last_q, last_nxt;
  logic [CTRL_BITS-1:0] ctrl_word;

  assign rsel    = reg_sel_e'(addr);
  assign wr_ctrl = sel && wr && (rsel == REG_CTRL);
  assign wr_send = sel && wr && (rsel == REG_SEND);
  assign rd_recv = sel && !wr && (rsel == REG_RECV);

  assign tx_push  = wr_send && en_q;
  assign rx_pop   = rd_recv && en_q && !rx_empty;
  assign tx_flush = wr_ctrl && wdata[CB_TX_FLUSH];
  assign err_set  = en_q && ((wr_send && tx_full) || (rd_recv && rx_empty));

  always_comb begin
    en_nxt   = wr_ctrl ? wdata[CB_ENABLE]   : en_q;
    txie_nxt = wr_ctrl ? wdata[CB_TX_IRQEN] : txie_q;
    rxie_nxt = wr_ctrl ? wdata[CB_RX_IRQEN] : rxie_q;
    err_nxt  = err_set || (err_q && !(wr_ctrl && wdata[CB_ERR]));
    last_nxt = rx_pop ? rx_head : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      txie_q <= 1'b0;
      rxie_q <= 1'b0;
      err_q  <= 1'b0;
      last_q <= '0;
    end else begin
      en_q   <= en_nxt;
      txie_q <= txie_nxt;
      rxie_q <= rxie_nxt;
      err_q  <= err_nxt;
      last_q <= last_nxt;
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CB_TX_EMPTY] = tx_empty;
    ctrl_word[CB_TX_FULL]  = tx_full;
    ctrl_word[CB_TX_IRQEN] = txie_q;
    ctrl_word[CB_RX_EMPTY] = rx_empty;
    ctrl_word[CB_RX_FULL]  = rx_full;
    ctrl_word[CB_RX_IRQEN] = rxie_q;
    ctrl_word[CB_ERR]      = err_q;
    ctrl_word[CB_ENABLE]   = en_q;
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      case (rsel)
        REG_CTRL: rdata = WIDTH'(ctrl_word);
        REG_RECV: rdata = (en_q && !rx_empty) ? rx_head : last_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq_tx_empty = txie_q && tx_empty;
  assign irq_rx_avail = rxie_q && !rx_empty;

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_recv && en_q && rx_empty) |=> err_q);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CB_ERR] && !err_set) |=> !err_q);

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctrl) |=> (err_q == $past(err_q) && last_q == $past(last_q)));

endmodule

// File: rtl/ipc_word_channel.sv
module ipc_word_channel #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_sel,
  input  logic             a_wr,
  input  logic [1:0]       a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic             a_irq_send_empty,
  output logic             a_irq_recv_avail,
  input  logic             b_sel,
  input  logic             b_wr,
  input  logic [1:0]       b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             b_irq_send_empty,
  output logic             b_irq_recv_avail
);

  localparam int unsigned SIDES = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;

  logic [SIDES-1:0] sel_v, wr_v, push_v, pop_v, flush_v, empty_v, full_v;
  logic [SIDES-1:0] irq_tx_v, irq_rx_v;
  logic [1:0]       addr_v  [SIDES];
  logic [WIDTH-1:0] wdata_v [SIDES];
  logic [WIDTH-1:0] rdata_v [SIDES];
  logic [WIDTH-1:0] head_v  [SIDES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel_v      = {b_sel, a_sel};
  assign wr_v       = {b_wr, a_wr};
  assign addr_v[0]  = a_addr;
  assign addr_v[1]  = b_addr;
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;

  assign a_rdata          = rdata_v[0];
  assign b_rdata          = rdata_v[1];
  assign a_irq_send_empty = irq_tx_v[0];
  assign b_irq_send_empty = irq_tx_v[1];
  assign a_irq_recv_avail = irq_rx_v[0];
  assign b_irq_recv_avail = irq_rx_v[1];

  // Queue g carries words from side g to the opposite side.
  for (genvar g = 0; g < SIDES; g++) begin : g_side
    localparam int unsigned PEER = SIDES - 1 - g;

    ipc_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_int_n),
      .push  (push_v[g]),
      .pdata (wdata_v[g]),
      .pop   (pop_v[g]),
      .flush (flush_v[g]),
      .head  (head_v[g]),
      .empty (empty_v[g]),
      .full  (full_v[g])
    );

    ipc_side_regs #(.WIDTH(WIDTH)) u_regs (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .sel          (sel_v[g]),
      .wr           (wr_v[g]),
      .addr         (addr_v[g]),
      .wdata        (wdata_v[g]),
      .rdata        (rdata_v[g]),
      .tx_empty     (empty_v[g]),
      .tx_full      (full_v[g]),
      .rx_empty     (empty_v[PEER]),
      .rx_full      (full_v[PEER]),
      .rx_head      (head_v[PEER]),
      .tx_push      (push_v[g]),
      .tx_flush     (flush_v[g]),
      .rx_pop       (pop_v[PEER]),
      .irq_tx_empty (irq_tx_v[g]),
      .irq_rx_avail (irq_rx_v[g])
    );
  end

endmodule

// File: tb/ipc_word_channel_tb.sv
module ipc_word_channel_tb;

  localparam int unsigned WIDTH = 32;
  localparam int unsigned DEPTH = 4;

  logic             clk, rst_n;
  logic             a_sel, a_wr, b_sel, b_wr;
  logic [1:0]       a_addr, b_addr;
  logic [WIDTH-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic             a_irq_send_empty, a_irq_recv_avail;
  logic             b_irq_send_empty, b_irq_recv_avail;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model
  logic [31:0] qa[$];
  logic [31:0] qb[$];
  bit          m_en   [2];
  bit          m_txie [2];
  bit          m_rxie [2];
  bit          m_err  [2];
  logic [31:0] m_last [2];

  ipc_word_channel #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_irq_send_empty(a_irq_send_empty), .a_irq_recv_avail(a_irq_recv_avail),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_irq_send_empty(b_irq_send_empty), .b_irq_recv_avail(b_irq_recv_avail)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int qsize(input int q);
    return (q == 0) ? qa.size() : qb.size();
  endfunction

  task automatic acc(input int s, input bit w, input logic [1:0] ad,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    if (s == 0) begin a_sel = 1; a_wr = w; a_addr = ad; a_wdata = d; end
    else        begin b_sel = 1; b_wr = w; b_addr = ad; b_wdata = d; end
    #1 q = (s == 0) ? a_rdata : b_rdata;
    @(posedge clk);
    #1;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic send(input int s, input logic [31:0] d);
    logic [31:0] q;
    acc(s, 1, 2'd2, d, q);
    if (m_en[s]) begin
      if (qsize(s) < DEPTH) begin
        if (s == 0) qa.push_back(d); else qb.push_back(d);
      end else m_err[s] = 1;
    end
  endtask

  task automatic recv(input int s, input string req);
    logic [31:0] q, e;
    int src;
    src = 1 - s;
    acc(s, 0, 2'd3, 32'h0, q);
    if (m_en[s] && qsize(src) > 0) begin
      e = (src == 0) ? qa.pop_front() : qb.pop_front();
      m_last[s] = e;
    end else begin
      e = m_last[s];
      if (m_en[s]) m_err[s] = 1;
    end
    chk(req, q, e);
  endtask

  task automatic wctrl(input int s, input logic [31:0] d);
    logic [31:0] q;
    acc(s, 1, 2'd1, d, q);
    if (d[3]) begin
      if (s == 0) qa.delete(); else qb.delete();
    end
    if (d[14]) m_err[s] = 0;
    m_en[s]   = d[15];
    m_txie[s] = d[2];
    m_rxie[s] = d[10];
  endtask

  function automatic logic [31:0] exp_ctrl(input int s);
    logic [31:0] v;
    v = '0;
    v[0]  = (qsize(s) == 0);
    v[1]  = (qsize(s) == DEPTH);
    v[2]  = m_txie[s];
    v[8]  = (qsize(1 - s) == 0);
    v[9]  = (qsize(1 - s) == DEPTH);
    v[10] = m_rxie[s];
    v[14] = m_err[s];
    v[15] = m_en[s];
    return v;
  endfunction

  task automatic chk_ctrl(input int s, input string req);
    logic [31:0] q;
    acc(s, 0, 2'd1, 32'h0, q);
    chk(req, q, exp_ctrl(s));
  endtask

  task automatic chk_irqs(input string req_tx, input string req_rx);
    chk(req_tx, {31'd0, a_irq_send_empty}, {31'd0, m_txie[0] && qsize(0) == 0});
    chk(req_tx, {31'd0, b_irq_send_empty}, {31'd0, m_txie[1] && qsize(1) == 0});
    chk(req_rx, {31'd0, a_irq_recv_avail}, {31'd0, m_rxie[0] && qsize(1) > 0});
    chk(req_rx, {31'd0, b_irq_recv_avail}, {31'd0, m_rxie[1] && qsize(0) > 0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    a_sel = 0; a_wr = 0; a_addr = 0; a_wdata = 0;
    b_sel = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    for (int i = 0; i < 2; i++) begin
      m_en[i] = 0; m_txie[i] = 0; m_rxie[i] = 0; m_err[i] = 0; m_last[i] = 0;
    end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    chk_ctrl(0, "R1");
    chk_ctrl(1, "R1");
    chk_irqs("R1", "R1");
    recv(0, "R1");
    recv(1, "R1");

    // R11: decode of unused and write-only offsets
    wctrl(0, 32'h8000);
    wctrl(1, 32'h8000);
    acc(0, 0, 2'd0, 32'h0, q); chk("R11", q, 32'h0);
    acc(1, 0, 2'd2, 32'h0, q); chk("R11", q, 32'h0);

    // R2 R3 R4 R5: sweep every fill level in both directions
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= DEPTH + 1; n++) begin
        for (int k = 0; k < n; k++)
          send(s, (32'(s + 1) << 28) | (32'(n) << 8) | 32'(k));
        chk_ctrl(s, "R3");
        chk_ctrl(1 - s, "R3");
        chk_ctrl(s, "R4");
        for (int k = 0; k < n + 1; k++) recv(1 - s, "R2");
        chk_ctrl(1 - s, "R5");
        wctrl(s, 32'hC000);
        wctrl(1 - s, 32'hC000);
        chk_ctrl(s, "R6");
      end
    end

    // R5: empty read leaves queue untouched, then the next word is intact
    recv(1, "R5");
    send(0, 32'hCAFE_0001);
    recv(1, "R5");
    chk_ctrl(1, "R5");

    // R6: writing bit 14 as 0 keeps the flag, writing 1 clears it
    wctrl(1, 32'h8000);
    chk_ctrl(1, "R6");
    wctrl(1, 32'hC000);
    chk_ctrl(1, "R6");

    // R7: flush and the no-op write of bit 3 = 0
    send(0, 32'h1111_0000); send(0, 32'h1111_0001); send(0, 32'h1111_0002);
    wctrl(0, 32'h8000);
    chk_ctrl(1, "R7");
    wctrl(0, 32'h8008);
    chk_ctrl(0, "R7");
    chk_ctrl(1, "R7");
    send(1, 32'h2222_0000); send(0, 32'h1111_0003);
    wctrl(1, 32'h8008);
    chk_ctrl(0, "R7");
    recv(1, "R7");
    chk_ctrl(1, "R7");

    // R8: enable gate
    wctrl(0, 32'h0000);
    send(0, 32'h3333_0000);
    chk_ctrl(1, "R8");
    chk_ctrl(0, "R8");
    wctrl(0, 32'h8000);
    wctrl(1, 32'h0000);
    send(0, 32'h3333_0001); send(0, 32'h3333_0002);
    recv(1, "R8");
    chk_ctrl(1, "R8");
    send(1, 32'h4444_0000);
    chk_ctrl(0, "R8");
    wctrl(1, 32'h0008);
    chk_ctrl(0, "R8");
    send(0, 32'h3333_0003);
    wctrl(1, 32'h8000);
    recv(1, "R8"); recv(1, "R8"); recv(1, "R8");

    // R9 R10: interrupt levels across transitions
    wctrl(0, 32'h8404);
    wctrl(1, 32'h8404);
    chk_irqs("R9", "R10");
    send(0, 32'h5555_0000);
    chk_irqs("R9", "R10");
    send(1, 32'h6666_0000);
    chk_irqs("R9", "R10");
    wctrl(1, 32'h8004);
    chk_irqs("R9", "R10");
    recv(1, "R10");
    chk_irqs("R9", "R10");
    wctrl(0, 32'h8400);
    chk_irqs("R9", "R10");
    recv(0, "R10");
    chk_irqs("R9", "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule